// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit down-counting timer channel. A counter-clock enable sets the pace of counting, and a gate input qualifies or retriggers it. A bus-side controller writes an initial count and an operating mode. The channel then produces an output waveform and a live count value. The controller can capture that count value when it needs to read it.

Six operating modes are available:

- two single-shot terminal-count modes, one started by software and one by hardware;
- a periodic rate generator;
- a square-wave generator;
- two single-strobe modes, one started by software and one by hardware.

Each mode uses the gate in its own way. The gate can pause counting, restart counting, or be ignored. BCD counting is not supported. Decoding of the bus is also outside this block.

Time is measured in ticks. A tick is a clock cycle in which the counter-clock enable is high and the gate rule of the current mode permits counting. The elapsed count E is the number of ticks since the last load or restart. N is the initial count.

Top module: `interval_counter`

## Requirements
- R1: After a synchronous reset the channel is in mode 0 with no count loaded, and it stays idle until a load arrives. While idle, `out` is 0, `count` is 0, and ticks and gate edges have no effect.
- R2: A loaded value of 0 means N = 65536. Right after such a load `count` reads 0. After one tick `count` reads 65535 and `out` is still 0.
- R3: Mode 0 (code 0). `out` is 1 once E >= N and stays 1 until the next load. `count` is (N - E) mod 65536. Gate low freezes counting without restarting it. `count` changes only on a tick, a load or a restart.
- R4: Mode 1 (code 1). `out` is 0 while E < N and 1 once E >= N. `count` is (N - E) mod 65536. Counting ignores the gate level. A rising gate edge sets E back to 0.
- R5: Mode 2 (code 2). The period is N ticks. `out` is 0 when E mod N = 0 and E > 0, and 1 otherwise. `count` is N - (E mod N), truncated to 16 bits.
- R6: Mode 3 (code 3). `out` is 1 when E mod N < (N+1)/2 and 0 otherwise. `count` is N - (2E mod N), so it falls by two per tick and wraps modulo N.
- R7: In modes 2 and 3, gate low forces `out` to 1 and halts counting. A rising gate edge restarts the period with E = 0.
- R8: Mode 4 (code 4). `out` is 1 only while E = N. This gives a single strobe that lasts one tick. Gate low pauses counting without restarting it.
- R9: Mode 5 (code 5). The strobe rule is the same as in mode 4. Counting ignores the gate level. A rising gate edge sets E back to 0.
- R10: A load applies the new mode and count on the next clock edge and sets E to 0. A load takes precedence over a tick or a gate edge in the same cycle.
- R11: Mode codes 6 and 7 behave exactly as codes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Counter-clock enable, one tick per high cycle |
| gate | input | 1 | Gate input, sampled each clock |
| load | input | 1 | Load strobe for a new count and mode |
| load_value | input | 16 | Initial count; 0 means 65536 |
| load_mode | input | 3 | Operating mode code |
| out | output | 1 | Output waveform |
| count | output | 16 | Live count value |

## Verification
Two functions can fall in the same clock cycle.

The first pair is a load together with a tick and a rising gate edge. The bench provokes this while a rate-generator run is under way. It drives `load`, `cnt_en` and a gate rise together. It then expects the new count and mode with E = 0, with no tick applied.

The second pair is a rising gate edge together with an enabled counter clock in a retriggering mode. Here the restart must win: the count reads N again instead of advancing.

A reference model in the bench keeps an unbounded elapsed count and the mode formulas. It predicts `out` and `count` after every edge.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

  typedef enum logic [2:0] {
    MD_TERM     = 3'd0,
    MD_ONESHOT  = 3'd1,
    MD_RATE     = 3'd2,
    MD_SQUARE   = 3'd3,
    MD_SWSTROBE = 3'd4,
    MD_HWSTROBE = 3'd5
  } ictr_mode_e;

  // codes 6 and 7 alias the two periodic modes
  function automatic ictr_mode_e fold_mode(input logic [2:0] code);
    case (code)
      3'd6:    return MD_RATE;
      3'd7:    return MD_SQUARE;
      default: return ictr_mode_e'(code);
    endcase
  endfunction

  function automatic logic is_periodic(input ictr_mode_e m);
    return (m == MD_RATE) || (m == MD_SQUARE);
  endfunction

  // a rising gate restarts the elapsed count
  function automatic logic gate_retriggers(input ictr_mode_e m);
    return (m == MD_ONESHOT) || (m == MD_RATE) ||
           (m == MD_SQUARE)  || (m == MD_HWSTROBE);
  endfunction

  // gate level must be high for ticks to count
  function automatic logic gate_qualifies(input ictr_mode_e m);
    return (m == MD_TERM) || (m == MD_SWSTROBE) ||
           (m == MD_RATE) || (m == MD_SQUARE);
  endfunction

endpackage

// File: rtl/ictr_gate_edge.sv
module ictr_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  output logic gate_rise
);

  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate;
  end

  assign gate_rise = gate & ~gate_q;

endmodule

// File: rtl/ictr_state.sv
module ictr_state
  import ictr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [W:0]      load_span,
  input  ictr_mode_e      load_mode,
  input  logic            restart,
  input  logic            tick,
  output ictr_mode_e      mode,
  output logic            armed,
  output logic [W:0]      span,
  output logic [W:0]      phase,
  output logic [W:0]      dbl,
  output logic [W-1:0]    down,
  output logic            moved
);

  localparam int SW = W + 1;

  // elapsed modulo span, for the periodic modes
  function automatic logic [SW-1:0] wrap_inc(input logic [SW-1:0] ph,
                                             input logic [SW-1:0] n);
    logic [SW-1:0] t;
    t = ph + SW'(1);
    return (t == n) ? '0 : t;
  endfunction

  // elapsed saturating at span+1, enough for the one-shot decodes
  function automatic logic [SW-1:0] sat_inc(input logic [SW-1:0] ph,
                                            input logic [SW-1:0] n);
    return (ph > n) ? ph : ph + SW'(1);
  endfunction

  // twice elapsed modulo span
  function automatic logic [SW-1:0] dbl_step(input logic [SW-1:0] q,
                                             input logic [SW-1:0] n);
    logic [SW:0] t;
    logic [SW:0] m;
    t = {1'b0, q} + (SW+1)'(2);
    m = {1'b0, n};
    if (t >= m) t = t - m;
    if (t >= m) t = t - m;
    return t[SW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= MD_TERM;
      armed <= 1'b0;
      span  <= '0;
      phase <= '0;
      dbl   <= '0;
      down  <= '0;
      moved <= 1'b0;
    end else if (load) begin
      mode  <= load_mode;
      armed <= 1'b1;
      span  <= load_span;
      phase <= '0;
      dbl   <= '0;
      down  <= load_span[W-1:0];
      moved <= 1'b0;
    end else if (restart) begin
      phase <= '0;
      dbl   <= '0;
      down  <= span[W-1:0];
      moved <= 1'b0;
    end else if (tick) begin
      moved <= 1'b1;
      down  <= down - W'(1);
      phase <= is_periodic(mode) ? wrap_inc(phase, span) : sat_inc(phase, span);
      dbl   <= dbl_step(dbl, span);
    end
  end

endmodule

// File: rtl/ictr_wave.sv
module ictr_wave
  import ictr_pkg::*;
#(
  parameter int W = 16
) (
  input  ictr_mode_e      mode,
  input  logic            armed,
  input  logic            gate,
  input  logic [W:0]      span,
  input  logic [W:0]      phase,
  input  logic [W:0]      dbl,
  input  logic [W-1:0]    down,
  input  logic            moved,
  output logic            out,
  output logic [W-1:0]    count
);

  localparam int SW = W + 1;

  // length of the high half of a square-wave period
  function automatic logic [SW-1:0] high_len(input logic [SW-1:0] n);
    logic [SW:0] t;
    t = {1'b0, n} + (SW+1)'(1);
    return t[SW:1];
  endfunction

  always_comb begin
    out   = 1'b0;
    count = down;
    if (armed) begin
      case (mode)
        MD_TERM, MD_ONESHOT:       out = (phase >= span);
        MD_RATE: begin
          out   = !gate || !((phase == '0) && moved);
          count = W'(span - phase);
        end
        MD_SQUARE: begin
          out   = !gate || (phase < high_len(span));
          count = W'(span - dbl);
        end
        MD_SWSTROBE, MD_HWSTROBE:  out = (phase == span);
        default:                   out = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/interval_counter.sv
module interval_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         gate,
  input  logic         load,
  input  logic [W-1:0] load_value,
  input  logic [2:0]   load_mode,
  output logic         out,
  output logic [W-1:0] count
);
  import ictr_pkg::*;

  localparam int SW = W + 1;

  ictr_mode_e    mode_q;
  ictr_mode_e    mode_in;
  logic          armed;
  logic [SW-1:0] span;
  logic [SW-1:0] phase;
  logic [SW-1:0] dbl;
  logic [W-1:0]  down;
  logic          moved;
  logic          gate_rise;
  logic          restart;
  logic          tick;
  logic [SW-1:0] load_span;

  // zero loads the full 2^W span
  assign load_span = {(load_value == '0), load_value};
  assign mode_in   = fold_mode(load_mode);
  assign restart   = armed & gate_rise & gate_retriggers(mode_q);
  assign tick      = armed & cnt_en & (gate | ~gate_qualifies(mode_q));

  ictr_gate_edge u_gate (
    .clk       (clk),
    .rst       (rst),
    .gate      (gate),
    .gate_rise (gate_rise)
  );

  ictr_state #(.W(W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_span (load_span),
    .load_mode (mode_in),
    .restart   (restart),
    .tick      (tick),
    .mode      (mode_q),
    .armed     (armed),
    .span      (span),
    .phase     (phase),
    .dbl       (dbl),
    .down      (down),
    .moved     (moved)
  );

  ictr_wave #(.W(W)) u_wave (
    .mode   (mode_q),
    .armed  (armed),
    .gate   (gate),
    .span   (span),
    .phase  (phase),
    .dbl    (dbl),
    .down   (down),
    .moved  (moved),
    .out    (out),
    .count  (count)
  );

endmodule

// File: rtl/interval_counter_chk.sv
module interval_counter_chk
  import ictr_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic [W-1:0] load_value,
  input logic         gate,
  input logic         out,
  input logic [W-1:0] count,
  input ictr_mode_e   mode,
  input logic         armed,
  input logic         tick,
  input logic         restart
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (!out && count == '0));

  a_r10_load_takes: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_value)));

  a_r3_term_sticks: assert property (@(posedge clk) disable iff (rst)
    (armed && mode == MD_TERM && out && !load) |=> out);

  a_r3_count_still: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load && !restart) |=> $stable(count));

  a_r7_gate_low_high: assert property (@(posedge clk) disable iff (rst)
    (armed && (mode == MD_RATE || mode == MD_SQUARE) && !gate) |-> out);

  a_r8_strobe_once: assert property (@(posedge clk) disable iff (rst)
    (armed && (mode == MD_SWSTROBE || mode == MD_HWSTROBE) && out && tick && !load)
      |=> !out);

endmodule

bind interval_counter interval_counter_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load       (load),
  .load_value (load_value),
  .gate       (gate),
  .out        (out),
  .count      (count),
  .mode       (mode_q),
  .armed      (armed),
  .tick       (tick),
  .restart    (restart)
);

// File: tb/test_interval_counter.sv
module test_interval_counter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        gate = 1'b0;
  logic        load = 1'b0;
  logic [15:0] load_value = '0;
  logic [2:0]  load_mode = '0;
  logic        out;
  logic [15:0] count;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  bit m_armed = 0;
  int m_mode = 0;
  int m_n = 0;
  int m_d = 0;
  bit m_gq = 0;

  always #10ns clk = ~clk;

  interval_counter i_interval_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .gate(gate), .load(load),
    .load_value(load_value), .load_mode(load_mode), .out(out), .count(count)
  );

  function automatic bit exp_out(input bit g);
    if (!m_armed) return 0;
    case (m_mode)
      0, 1: return m_d >= m_n;
      2: return !g || !((m_d % m_n) == 0 && m_d != 0);
      3: return !g || ((m_d % m_n) < (m_n + 1) / 2);
      default: return m_d == m_n;
    endcase
  endfunction

  function automatic int exp_cnt();
    if (!m_armed) return 0;
    case (m_mode)
      2: return (m_n - (m_d % m_n)) & 16'hFFFF;
      3: return (m_n - ((2 * m_d) % m_n)) & 16'hFFFF;
      default: return (m_n - m_d) & 16'hFFFF;
    endcase
  endfunction

  task automatic check(input string tag);
    bit eo;
    int ec;
    eo = exp_out(gate);
    ec = exp_cnt();
    total += 2;
    if (out !== eo) begin
      bad++;
      $display("FAIL %s out: actual=%0b expected=%0b (d=%0d)", tag, out, eo, m_d);
    end
    if (count !== ec[15:0]) begin
      bad++;
      $display("FAIL %s count: actual=%0d expected=%0d (d=%0d)", tag, count, ec, m_d);
    end
  endtask

  // one clock: drive at the falling edge, update model at rising edge, sample 5ns later
  task automatic cyc(input bit ld, input int val, input int code,
                     input bit en, input bit g, input string tag);
    bit rise;
    @(negedge clk);
    load = ld; load_value = val[15:0]; load_mode = code[2:0];
    cnt_en = en; gate = g;
    @(posedge clk);
    rise = g && !m_gq;
    m_gq = g;
    if (rst) begin
      m_armed = 0; m_mode = 0; m_n = 0; m_d = 0; m_gq = 0;
    end else if (ld) begin
      m_mode = (code == 6) ? 2 : (code == 7) ? 3 : code;
      m_n = (val == 0) ? 65536 : val;
      m_d = 0;
      m_armed = 1;
    end else if (m_armed && rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
      m_d = 0;
    end else if (m_armed && en && (g || m_mode == 1 || m_mode == 5)) begin
      m_d++;
    end
    #5ns;
    check(tag);
  endtask

  task automatic run(input int n, input bit en, input bit g, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, en, g, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cyc(0, 0, 0, 0, 0, "R1 reset");
    cyc(0, 0, 0, 0, 0, "R1 reset");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    cyc(0, 0, 0, 0, 0, "R1 idle");
    run(3, 1, 1, "R1 ticks ignored");
    cyc(0, 0, 0, 1, 0, "R1 gate fall ignored");
    cyc(0, 0, 0, 1, 1, "R1 gate rise ignored");
  endtask

  task automatic t_mode0();
    cyc(1, 5, 0, 0, 1, "R3 load");
    run(3, 1, 1, "R3 count");
    run(2, 1, 0, "R3 gate pause");
    run(2, 0, 1, "R3 enable low");
    run(5, 1, 1, "R3 terminal and wrap");
  endtask

  task automatic t_zero();
    cyc(1, 0, 0, 0, 1, "R2 load zero");
    run(4, 1, 1, "R2 full span");
  endtask

  task automatic t_mode1();
    cyc(1, 4, 1, 0, 0, "R4 load");
    run(6, 1, 0, "R4 gate low counts");
    cyc(0, 0, 0, 1, 1, "R4 rise restarts");
    run(3, 1, 1, "R4 after restart");
    cyc(0, 0, 0, 1, 0, "R4 gate fall");
    run(3, 1, 0, "R4 run");
  endtask

  task automatic t_mode2();
    cyc(1, 3, 2, 0, 1, "R5 load");
    run(10, 1, 1, "R5 rate");
    cyc(1, 1, 2, 0, 1, "R5 load one");
    run(3, 1, 1, "R5 rate one");
  endtask

  task automatic t_mode3();
    cyc(1, 5, 3, 0, 1, "R6 load odd");
    run(12, 1, 1, "R6 odd");
    cyc(1, 6, 3, 0, 1, "R6 load even");
    run(12, 1, 1, "R6 even");
  endtask

  task automatic t_gate_periodic();
    cyc(1, 6, 3, 0, 1, "R7 load");
    run(4, 1, 1, "R7 run");
    run(3, 1, 0, "R7 gate low");
    cyc(0, 0, 0, 1, 1, "R7 rise restarts");
    run(6, 1, 1, "R7 after restart");
    cyc(1, 4, 2, 0, 1, "R7 load rate");
    run(4, 1, 1, "R7 rate run");
    run(2, 1, 0, "R7 rate gate low");
    cyc(0, 0, 0, 1, 1, "R7 rate rise");
    run(5, 1, 1, "R7 rate after");
  endtask

  task automatic t_mode4();
    cyc(1, 3, 4, 0, 1, "R8 load");
    run(2, 1, 1, "R8 run");
    run(2, 1, 0, "R8 gate pause");
    run(4, 1, 1, "R8 strobe");
  endtask

  task automatic t_mode5();
    cyc(1, 3, 5, 0, 0, "R9 load");
    run(5, 1, 0, "R9 gate low counts");
    cyc(0, 0, 0, 1, 1, "R9 rise retriggers");
    run(5, 1, 1, "R9 strobe again");
  endtask

  task automatic t_reload();
    cyc(1, 7, 2, 0, 0, "R10 load");
    run(4, 1, 0, "R10 run gate low");
    run(3, 1, 1, "R10 run");
    cyc(0, 0, 0, 1, 0, "R10 gate fall");
    cyc(1, 2, 0, 1, 1, "R10 load beats tick and rise");
    run(4, 1, 1, "R10 new mode");
  endtask

  task automatic t_alias();
    cyc(1, 4, 6, 0, 1, "R11 code 6");
    run(9, 1, 1, "R11 as rate");
    cyc(1, 4, 7, 0, 1, "R11 code 7");
    run(9, 1, 1, "R11 as square");
  endtask

  initial begin
    t_reset();
    t_mode0();
    t_zero();
    t_mode1();
    t_mode2();
    t_mode3();
    t_gate_periodic();
    t_mode4();
    t_mode5();
    t_reload();
    t_alias();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule